// File: doc/BRIEF.md
# Single-Buffer Serial Port on an APB Bus

This block is a serial port for a peripheral bus. Software writes a byte to a data register and reads received bytes from the same register. Each direction holds exactly one byte. The frame format is fixed: one start bit, eight data bits sent least significant bit first, no parity, and one stop bit. A 20-bit divider of the bus clock sets the bit period. Any divider below 16 holds both serial engines idle.

All data passes through the bus registers; the block has no streaming port. Back-pressure is visible to software only through the status flags. The transmit-full flag shows that the holding byte has not yet been taken by the shifter. The receive-full flag shows that a byte is waiting to be read. A write or an arrival that meets a full buffer replaces the byte and sets a sticky overrun flag. Four interrupt lines and one combined line report these events.

Register map (byte offsets, 32-bit words): data 0x000, status 0x004, control 0x008, interrupt status 0x00C, divider 0x010. A read-only identification window covers 0xFD0 to 0xFFC.

Top module: `apb_serial_port`

## Requirements
- R1: After reset, the status, control, interrupt-status, divider and receive-data registers read 0, `txd` is high and all interrupt outputs are low.
- R2: Control keeps only bits 6:0 and discards higher written bits. The bits are: 0 transmit enable, 1 receive enable, 2 transmit interrupt enable, 3 receive interrupt enable, 4 transmit-overrun interrupt enable, 5 receive-overrun interrupt enable, 6 a stored test bit.
- R3: The divider keeps bits 19:0 of a write and reads them back.
- R4: While the divider is below 16, `txd` stays high and a pending transmit byte keeps status bit 0 set. When a valid divider is written, that byte is sent.
- R5: A frame is a low start bit, then eight data bits least significant bit first, then a high stop bit, each lasting divider clocks. Looping `txd` to `rxd` returns the written byte.
- R6: Status bit 0 (transmit full) sets on a data write and clears when the shifter takes the byte. Status bit 1 (receive full) sets on a received byte. A data read returns the received byte and clears bit 1.
- R7: Interrupt-status bit 0 sets when transmit full goes from 1 to 0 while control bit 2 is set, and is cleared by writing 1 to it. `irq_tx` mirrors it and `irq_any` is the OR of all four interrupt-status bits.
- R8: Interrupt-status bit 1 sets on a received byte while control bit 3 is set. It stays set across a data read until software writes 1 to it. `irq_rx` mirrors it.
- R9: A data write while transmit full is set replaces the pending byte and sets status bit 2 (transmit overrun).
- R10: Interrupt-status bits 2 and 3 equal status bits 2 and 3 ANDed with control bits 4 and 5, at all times. Writing 1 to those bits of either interrupt status or status clears the overrun flags. Status bits 0 and 1 ignore writes.
- R11: A byte that arrives while receive full is set sets status bit 3 (receive overrun) and overwrites the buffer.
- R12: With control bit 1 clear, a received frame is dropped: receive full and the receive buffer are unchanged.
- R13: The receiver samples the start bit half a divider after the line falls and abandons the frame if the line is high there. It discards a frame whose stop bit samples low.
- R14: Word k (k = 0..11) of the window at 0xFD0 reads 0xA0 + 3k. Unmapped offsets read 0, and writes to them or to the window have no effect. `pready` is always 1 and `pslverr` always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and serial clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | 12 | Byte offset within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Transfer error, always low |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_txovr | output | 1 | Transmit overrun interrupt |
| irq_rxovr | output | 1 | Receive overrun interrupt |
| irq_any | output | 1 | OR of the four interrupts |

## Verification
The hardest situation to reach is a transmit overrun with the transmitter enabled. The shifter takes the holding byte one cycle after each write, so a second write normally finds the buffer empty. The bench reaches the overrun by issuing three writes back to back during one frame: the first is taken by the shifter, the second waits behind the busy shifter, and the third overruns it. The loopback must then deliver the first and third bytes. A start glitch and a frame with a low stop bit cannot come from the transmitter, so the bench opens the loop and drives `rxd` itself. It holds the bad stop bit low for three quarters of a bit, so that the rejected frame does not also produce a false start bit.

// File: rtl/serport_pkg.sv
package serport_pkg;

  localparam logic [11:0] OFS_DATA  = 12'h000;
  localparam logic [11:0] OFS_STAT  = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_INTS  = 12'h00C;
  localparam logic [11:0] OFS_BDIV  = 12'h010;
  localparam logic [11:0] OFS_ID_LO = 12'hFD0;

  localparam int CTRL_W    = 7;
  localparam int CTL_TXEN  = 0;
  localparam int CTL_RXEN  = 1;
  localparam int CTL_TXIE  = 2;
  localparam int CTL_RXIE  = 3;
  localparam int CTL_TXOIE = 4;
  localparam int CTL_RXOIE = 5;

  // status word, msb first: rx overrun, tx overrun, rx full, tx full
  typedef struct packed {
    logic rxovr;
    logic txovr;
    logic rxfull;
    logic txfull;
  } stat_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    return 8'hA0 + 8'(k) * 8'd3;
  endfunction

endpackage

// File: rtl/serport_tx.sv
module serport_tx #(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              div_ok_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [BCNT_W-1:0]  bitcnt;
  logic [DIV_W-1:0]   cnt;
  logic               busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '1;
      bitcnt <= '0;
      cnt    <= '0;
    end else if (!div_ok_i) begin
      busy   <= 1'b0;
      bitcnt <= '0;
      cnt    <= '0;
    end else if (!busy && start_i) begin
      busy   <= 1'b1;
      shreg  <= {1'b1, data_i, 1'b0};
      bitcnt <= '0;
      cnt    <= '0;
    end else if (busy) begin
      if (cnt == div_i - DIV_W'(1)) begin
        cnt   <= '0;
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        if (bitcnt == BCNT_W'(FRAME_W - 1)) busy <= 1'b0;
        else bitcnt <= bitcnt + BCNT_W'(1);
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assign busy_o = busy;
  assign txd_o  = busy ? shreg[0] : 1'b1;

  // R4: an invalid divider returns the line to idle on the next cycle
  p_idle_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok_i |=> txd_o);

endmodule

// File: rtl/serport_rx.sv
module serport_rx
  import serport_pkg::*;
#(
  parameter int DIV_W  = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              div_ok_i,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              rxd_m, rxd_s;
  rx_st_t            st;
  logic [DIV_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              valid;
  logic [DIV_W-1:0]  half;
  logic              bit_end;

  assign half    = div_i >> 1;
  assign bit_end = (cnt == div_i - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RX_IDLE;
      cnt    <= '0;
      bitcnt <= '0;
      shreg  <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!div_ok_i) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          RX_IDLE: begin
            cnt <= '0;
            if (!rxd_s) st <= RX_START;
          end
          RX_START: begin
            if (cnt == half - DIV_W'(1)) begin
              cnt    <= '0;
              bitcnt <= '0;
              st     <= rxd_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[DATA_W-1:1]};
              if (bitcnt == BIT_W'(DATA_W - 1)) st <= RX_STOP;
              else bitcnt <= bitcnt + BIT_W'(1);
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              cnt   <= '0;
              st    <= RX_IDLE;
              valid <= rxd_s;
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o  = shreg;
  assign valid_o = valid;

  // R13: a byte is only delivered when the stop sample was high
  p_stop_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(rxd_s));

endmodule

// File: rtl/apb_serial_port.sv
module apb_serial_port
  import serport_pkg::*;
#(
  parameter int DIV_W   = 20,
  parameter int MIN_DIV = 16
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  input  logic        rxd,
  output logic        txd,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        irq_txovr,
  output logic        irq_rxovr,
  output logic        irq_any
);
  localparam int DATA_W = 8;

  logic              acc, wr, rd;
  logic [11:0]       addr_w;
  logic              wr_data, rd_data, wr_stat, wr_ctrl, wr_ints, wr_bdiv;
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  bdiv;
  logic [DATA_W-1:0] txbuf, rxbuf;
  stat_t             st;
  logic              int_tx, int_rx;
  logic [3:0]        intstat;
  logic              div_ok;
  logic              tx_busy, tx_start;
  logic [DATA_W-1:0] rx_data;
  logic              rx_valid, rx_take;
  logic              clr_txovr, clr_rxovr;
  logic [11:0]       id_off;
  logic [31:0]       rdv;

  assign acc     = psel & penable;
  assign wr      = acc & pwrite;
  assign rd      = acc & ~pwrite;
  assign addr_w  = {paddr[11:2], 2'b00};
  assign wr_data = wr && addr_w == OFS_DATA;
  assign rd_data = rd && addr_w == OFS_DATA;
  assign wr_stat = wr && addr_w == OFS_STAT;
  assign wr_ctrl = wr && addr_w == OFS_CTRL;
  assign wr_ints = wr && addr_w == OFS_INTS;
  assign wr_bdiv = wr && addr_w == OFS_BDIV;

  assign div_ok    = bdiv >= DIV_W'(MIN_DIV);
  // a data write in the same cycle wins; the shifter takes the byte a cycle later
  assign tx_start  = st.txfull && ctrl[CTL_TXEN] && div_ok && !tx_busy && !wr_data;
  assign rx_take   = rx_valid && ctrl[CTL_RXEN];
  assign clr_txovr = (wr_stat || wr_ints) && pwdata[2];
  assign clr_rxovr = (wr_stat || wr_ints) && pwdata[3];

  serport_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(pclk), .rst_n(presetn), .div_i(bdiv), .div_ok_i(div_ok),
    .start_i(tx_start), .data_i(txbuf), .busy_o(tx_busy), .txd_o(txd)
  );

  serport_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(pclk), .rst_n(presetn), .div_i(bdiv), .div_ok_i(div_ok),
    .rxd_i(rxd), .data_o(rx_data), .valid_o(rx_valid)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl   <= '0;
      bdiv   <= '0;
      txbuf  <= '0;
      rxbuf  <= '0;
      st     <= '0;
      int_tx <= 1'b0;
      int_rx <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= pwdata[CTRL_W-1:0];
      if (wr_bdiv) bdiv <= pwdata[DIV_W-1:0];
      if (wr_data) txbuf <= pwdata[DATA_W-1:0];
      if (rx_take) rxbuf <= rx_data;

      if (wr_data) st.txfull <= 1'b1;
      else if (tx_start) st.txfull <= 1'b0;

      if (wr_data && st.txfull) st.txovr <= 1'b1;
      else if (clr_txovr) st.txovr <= 1'b0;

      if (rx_take) st.rxfull <= 1'b1;
      else if (rd_data) st.rxfull <= 1'b0;

      if (rx_take && st.rxfull) st.rxovr <= 1'b1;
      else if (clr_rxovr) st.rxovr <= 1'b0;

      if (tx_start && ctrl[CTL_TXIE]) int_tx <= 1'b1;
      else if (wr_ints && pwdata[0]) int_tx <= 1'b0;

      if (rx_take && ctrl[CTL_RXIE]) int_rx <= 1'b1;
      else if (wr_ints && pwdata[1]) int_rx <= 1'b0;
    end
  end

  assign intstat = {st.rxovr & ctrl[CTL_RXOIE], st.txovr & ctrl[CTL_TXOIE], int_rx, int_tx};

  assign id_off = addr_w - OFS_ID_LO;

  always_comb begin
    rdv = '0;
    case (addr_w)
      OFS_DATA: rdv = {{(32-DATA_W){1'b0}}, rxbuf};
      OFS_STAT: rdv = 32'(st);
      OFS_CTRL: rdv = {{(32-CTRL_W){1'b0}}, ctrl};
      OFS_INTS: rdv = {28'b0, intstat};
      OFS_BDIV: rdv = {{(32-DIV_W){1'b0}}, bdiv};
      default:  if (addr_w >= OFS_ID_LO) rdv = {24'b0, id_byte(id_off[5:2])};
    endcase
  end

  assign prdata    = rd ? rdv : 32'b0;
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;
  assign irq_tx    = intstat[0];
  assign irq_rx    = intstat[1];
  assign irq_txovr = intstat[2];
  assign irq_rxovr = intstat[3];
  assign irq_any   = |intstat;

  logic unused_bits;
  assign unused_bits = ^{pwdata[31:DIV_W], id_off[11:6], id_off[1:0]};

  // R6: transmit full only falls when the shifter takes the byte
  p_txfull_fall_r6: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(st.txfull) |-> $past(tx_start));

  // R7: the transmit interrupt only rises on a hand-off with its enable set
  p_txint_set_r7: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(int_tx) |-> $past(tx_start && ctrl[CTL_TXIE]));

  // R11: receive overrun only rises when a byte lands on a full buffer
  p_rxovr_set_r11: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(st.rxovr) |-> $past(rx_take && st.rxfull));

  // R12: with the receiver disabled a delivered frame changes nothing
  p_rx_drop_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (rx_valid && !ctrl[CTL_RXEN] && !rd_data) |=> ($stable(st.rxfull) && $stable(rxbuf)));

endmodule

// File: tb/apb_serial_port_tb.sv
module apb_serial_port_tb;
  localparam logic [11:0] A_DATA = 12'h000, A_STAT = 12'h004, A_CTRL = 12'h008,
                          A_INTS = 12'h00C, A_BDIV = 12'h010, A_ID = 12'hFD0;

  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, txd, rxd;
  logic        irq_tx, irq_rx, irq_txovr, irq_rxovr, irq_any;
  logic        loop_en = 1'b1;
  logic        rxd_drv = 1'b1;
  int          n_chk = 0, n_fail = 0;
  int          cur_div = 16;

  assign rxd = loop_en ? txd : rxd_drv;

  always #4 clk = ~clk;

  apb_serial_port u_dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txovr(irq_txovr),
    .irq_rxovr(irq_rxovr), .irq_any(irq_any)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    apb_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wait_rxfull(input string tag);
    logic [31:0] v;
    logic        seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      apb_rd(A_STAT, v);
      if (v[1]) seen = 1'b1;
    end
    chk(tag, 32'(seen), 32'd1);
  endtask

  task automatic drive_frame(input logic [7:0] b, input int stop_len);
    logic [9:0] f;
    f = {1'b0, b, 1'b0};
    @(negedge clk);
    for (int i = 0; i < 9; i++) begin
      rxd_drv = f[i];
      repeat (cur_div) @(negedge clk);
    end
    rxd_drv = 1'b0;
    repeat (stop_len) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (cur_div) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        low_seen;
    repeat (5) @(negedge clk);
    presetn = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", 32'(txd), 32'd1);
    chk("R1 irq_any", 32'(irq_any), 32'd0);
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 control", A_CTRL, 32'h0);
    rd_chk("R1 int status", A_INTS, 32'h0);
    rd_chk("R1 divider", A_BDIV, 32'h0);
    rd_chk("R1 rx data", A_DATA, 32'h0);

    // R2 control width
    apb_wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R2 control masked", A_CTRL, 32'h7F);
    apb_wr(A_CTRL, 32'h0);

    // R3 divider width
    apb_wr(A_BDIV, 32'hFFFF_FFFF);
    rd_chk("R3 divider masked", A_BDIV, 32'h000F_FFFF);

    // R14 identification window and unmapped space
    for (int k = 0; k < 12; k++) rd_chk("R14 id word", A_ID + 12'(4 * k), 32'(8'hA0 + 8'(3 * k)));
    apb_wr(A_ID, 32'h0);
    rd_chk("R14 id write ignored", A_ID, 32'hA0);
    apb_wr(12'h014, 32'hFFFF_FFFF);
    rd_chk("R14 unmapped 0x014", 12'h014, 32'h0);
    rd_chk("R14 unmapped 0x800", 12'h800, 32'h0);
    rd_chk("R14 unmapped write no effect", A_CTRL, 32'h0);
    chk("R14 pready", 32'(pready), 32'd1);
    chk("R14 pslverr", 32'(pslverr), 32'd0);

    // R4 invalid divider holds transmitter idle
    apb_wr(A_BDIV, 32'd8);
    apb_wr(A_CTRL, 32'h1);
    apb_wr(A_DATA, 32'h3C);
    low_seen = 1'b0;
    repeat (100) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
    chk("R4 txd stays high", 32'(low_seen), 32'd0);
    rd_chk("R4 tx full held", A_STAT, 32'h1);
    apb_wr(A_CTRL, 32'h3);
    apb_wr(A_BDIV, 32'd16);
    wait_rxfull("R4 pending byte sent");
    rd_chk("R4 pending byte data", A_DATA, 32'h3C);

    // R5/R6 loopback sweep
    for (int d = 0; d < 3; d++) begin
      int div;
      int step;
      div = (d == 0) ? 16 : (d == 1) ? 19 : 32;
      step = (d == 0) ? 1 : 37;
      apb_wr(A_BDIV, 32'(div));
      for (int b = 0; b < 256; b += step) begin
        apb_wr(A_DATA, 32'(b));
        wait_rxfull("R5 frame arrives");
        rd_chk("R6 status after frame", A_STAT, 32'h2);
        rd_chk("R5 loopback byte", A_DATA, 32'(b));
        rd_chk("R6 rx full cleared by read", A_STAT, 32'h0);
      end
    end
    apb_wr(A_BDIV, 32'd16);

    // R9/R10 transmit overrun with transmitter disabled
    apb_wr(A_CTRL, 32'h02);
    apb_wr(A_DATA, 32'h11);
    rd_chk("R6 tx full set by write", A_STAT, 32'h1);
    apb_wr(A_DATA, 32'h22);
    rd_chk("R9 tx overrun set", A_STAT, 32'h5);
    apb_wr(A_CTRL, 32'h12);
    rd_chk("R10 txo int bit", A_INTS, 32'h4);
    chk("R10 irq_txovr", 32'(irq_txovr), 32'd1);
    chk("R7 irq_any", 32'(irq_any), 32'd1);
    apb_wr(A_CTRL, 32'h02);
    rd_chk("R10 txo int follows enable", A_INTS, 32'h0);
    rd_chk("R10 overrun kept", A_STAT, 32'h5);
    apb_wr(A_CTRL, 32'h12);
    apb_wr(A_INTS, 32'h4);
    rd_chk("R10 int clear clears status", A_STAT, 32'h1);
    chk("R10 irq_txovr cleared", 32'(irq_txovr), 32'd0);
    apb_wr(A_CTRL, 32'h03);
    wait_rxfull("R9 replaced byte sent");
    rd_chk("R9 replaced byte", A_DATA, 32'h22);
    apb_wr(A_CTRL, 32'h02);
    apb_wr(A_DATA, 32'h33);
    apb_wr(A_DATA, 32'h44);
    apb_wr(A_STAT, 32'h0F);
    rd_chk("R10 status w1c, low bits read-only", A_STAT, 32'h1);
    apb_wr(A_CTRL, 32'h03);
    wait_rxfull("R9 second replaced byte sent");
    rd_chk("R9 second replaced byte", A_DATA, 32'h44);

    // R9 overrun while the shifter is busy
    apb_wr(A_DATA, 32'hC1);
    apb_wr(A_DATA, 32'hC2);
    apb_wr(A_DATA, 32'hC3);
    rd_chk("R9 overrun during frame", A_STAT, 32'h5);
    wait_rxfull("R9 first frame");
    rd_chk("R9 first byte", A_DATA, 32'hC1);
    wait_rxfull("R9 overrun frame");
    rd_chk("R9 last written byte", A_DATA, 32'hC3);
    apb_wr(A_STAT, 32'h4);
    rd_chk("R9 status clean", A_STAT, 32'h0);

    // R7 transmit interrupt
    apb_wr(A_CTRL, 32'h07);
    apb_wr(A_DATA, 32'h5A);
    rd_chk("R7 tx int set", A_INTS, 32'h1);
    chk("R7 irq_tx", 32'(irq_tx), 32'd1);
    chk("R7 irq_any on tx", 32'(irq_any), 32'd1);
    wait_rxfull("R7 frame");
    rd_chk("R7 data", A_DATA, 32'h5A);
    apb_wr(A_INTS, 32'h1);
    rd_chk("R7 tx int cleared", A_INTS, 32'h0);
    chk("R7 irq_tx cleared", 32'(irq_tx), 32'd0);
    apb_wr(A_CTRL, 32'h03);
    apb_wr(A_DATA, 32'h6B);
    wait_rxfull("R7 frame no enable");
    rd_chk("R7 no int without enable", A_INTS, 32'h0);
    rd_chk("R7 data no enable", A_DATA, 32'h6B);

    // R8 receive interrupt
    apb_wr(A_CTRL, 32'h0B);
    apb_wr(A_DATA, 32'h96);
    wait_rxfull("R8 frame");
    rd_chk("R8 rx int set", A_INTS, 32'h2);
    chk("R8 irq_rx", 32'(irq_rx), 32'd1);
    rd_chk("R8 data", A_DATA, 32'h96);
    rd_chk("R8 int sticky across read", A_INTS, 32'h2);
    apb_wr(A_INTS, 32'h2);
    rd_chk("R8 rx int cleared", A_INTS, 32'h0);
    chk("R8 irq_rx cleared", 32'(irq_rx), 32'd0);

    // R11 receive overrun
    apb_wr(A_CTRL, 32'h23);
    apb_wr(A_DATA, 32'h12);
    wait_rxfull("R11 first frame");
    apb_wr(A_DATA, 32'h34);
    repeat (12 * 16 + 20) @(negedge clk);
    rd_chk("R11 rx overrun status", A_STAT, 32'hA);
    rd_chk("R11 rxo int", A_INTS, 32'h8);
    chk("R11 irq_rxovr", 32'(irq_rxovr), 32'd1);
    rd_chk("R11 overwritten byte", A_DATA, 32'h34);
    apb_wr(A_INTS, 32'h8);
    rd_chk("R11 cleared", A_STAT, 32'h0);
    chk("R11 irq_rxovr cleared", 32'(irq_rxovr), 32'd0);

    // R12 receiver disabled
    apb_wr(A_CTRL, 32'h01);
    apb_wr(A_DATA, 32'h77);
    repeat (220) @(negedge clk);
    rd_chk("R12 rx full untouched", A_STAT, 32'h0);
    rd_chk("R12 buffer untouched", A_DATA, 32'h34);

    // R13 start glitch and bad stop, line driven by the bench
    loop_en = 1'b0;
    rxd_drv = 1'b1;
    apb_wr(A_CTRL, 32'h02);
    cur_div = 16;
    @(negedge clk); rxd_drv = 1'b0;
    repeat (4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (220) @(negedge clk);
    rd_chk("R13 glitch rejected", A_STAT, 32'h0);
    drive_frame(8'h5D, 12);
    repeat (40) @(negedge clk);
    rd_chk("R13 bad stop rejected", A_STAT, 32'h0);
    drive_frame(8'hE4, 0);
    repeat (20) @(negedge clk);
    rd_chk("R13 good frame accepted", A_STAT, 32'h2);
    rd_chk("R5 driven frame data", A_DATA, 32'hE4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule